// File: doc/BRIEF.md
# Multiply-Accumulate Sequencer for Memory Arrays

This block walks two arrays of signed elements in memory and accumulates the products of matching elements into a wide sum. A start pulse loads both base addresses, an element count, an element width code, and a 96-bit starting sum given as three 32-bit words. For each element the sequencer reads one value from each array and sign-extends it. It multiplies the two values as signed 32-bit numbers and adds the 64-bit product, sign-extended, into the sum.

When the count reaches zero, the top word is reduced to 16 significant bits by sign extension from its bit 15. The block then raises an overflow flag and a sign flag from that final word. It also reports a cycle figure computed from the element count and width.

Memory reads go through a single read-only port. The memory returns data one cycle after a request, with the addressed element right-aligned in the data word. The block is busy from start until done, and it ignores any start that arrives while it is busy.

Top module: `sop_sequencer`

## Requirements
- R1: `busy` is high from the cycle after an accepted start until `done` is raised. `busy` is low in the `done` cycle. A `start` seen while `busy` is high has no effect on the run or on its results.
- R2: Each element uses three cycles. The block requests the address from array A, then the address from array B, then accumulates. `done` rises 3n+2 cycles after the start edge. `mem_req` is high only while busy, for exactly 2n cycles per run.
- R3: `elem_size` code 0 selects bytes, 1 selects halfwords, and 2 or 3 select words. Both pointers advance by 1, 2 or 4 bytes per element.
- R4: For byte and halfword elements, the low 8 or 16 bits of `mem_rdata` are sign-extended before a signed 32x32 multiply that gives a 64-bit product.
- R5: Before the final step, the sum equals the initial 96-bit value `{init_hi, init_mid, init_lo}` plus all sign-extended products, modulo 2^96. The carries ripple from the low word through the middle word into the top word.
- R6: At completion, bits 31:16 of `sum_hi` are all copies of bit 15. `sum_lo` and `sum_mid` are left as accumulated.
- R7: `flag_sign` equals bit 31 of the final `sum_hi`.
- R8: `flag_ovf` is 1 exactly when the final `sum_hi` is neither 0 nor 0xFFFFFFFF.
- R9: `cycle_est` is 6+4n for bytes, 6+5*(n/2)+4*(n%2) for halfwords, and 6+7*(n/4)+4*(n%4) for words, using integer division.
- R10: A count of zero makes no memory request and raises `done` two cycles after start. The only change to the sum is the sign handling of R6.
- R11: `done` is a one-cycle pulse. The sums, flags and `cycle_est` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; ignored while busy |
| base_a | input | ADDR_W | Byte address of the first array |
| base_b | input | ADDR_W | Byte address of the second array |
| elem_count | input | CNT_W | Number of element pairs |
| elem_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| init_lo | input | 32 | Starting sum, bits 31:0 |
| init_mid | input | 32 | Starting sum, bits 63:32 |
| init_hi | input | 32 | Starting sum, bits 95:64 |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after the request, element right-aligned |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| sum_lo | output | 32 | Sum, bits 31:0 |
| sum_mid | output | 32 | Sum, bits 63:32 |
| sum_hi | output | 32 | Sum, bits 95:64 (sign-extended at completion) |
| flag_ovf | output | 1 | Final top word is not a pure sign word |
| flag_sign | output | 1 | Bit 31 of the final top word |
| cycle_est | output | CYC_W | Cycle figure for the run |

## Verification
The embedded assertions check on every cycle the properties that hold locally. These are: requests only while busy, pointer stepping per accumulate, the one-cycle `done` pulse with `busy` low, a stable `cycle_est` during a run, and the consistency of the final top word with both flags. Only the bench's scenarios can show the arithmetic end to end. It compares against a bench model the addresses fetched, the sign extension per width, the 96-bit carry chain, the latency and `cycle_est` per width, and the ignored mid-run start. Those scenarios cover random data with random starting sums and extreme operands such as repeated 0x80000000 words.

// File: rtl/sop_sequencer.sv
module sop_sequencer #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [CNT_W-1:0]  elem_count,
  input  logic [1:0]        elem_size,
  input  logic [31:0]       init_lo,
  input  logic [31:0]       init_mid,
  input  logic [31:0]       init_hi,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       sum_lo,
  output logic [31:0]       sum_mid,
  output logic [31:0]       sum_hi,
  output logic              flag_ovf,
  output logic              flag_sign,
  output logic [CYC_W-1:0]  cycle_est
);

  typedef enum logic [2:0] {S_IDLE, S_RDA, S_RDB, S_MAC, S_FIN} state_t;

  state_t            state;
  logic [ADDR_W-1:0] ptr_a, ptr_b;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        size_q;
  logic [31:0]       opa;
  logic [95:0]       acc;

  function automatic logic [31:0] widen(input logic [31:0] w, input logic [1:0] sz);
    case (sz)
      2'd0:    widen = {{24{w[7]}}, w[7:0]};
      2'd1:    widen = {{16{w[15]}}, w[15:0]};
      default: widen = w;
    endcase
  endfunction

  function automatic logic [CYC_W-1:0] est(input logic [CNT_W-1:0] n, input logic [1:0] sz);
    logic [CYC_W-1:0] m;
    m = CYC_W'(n);
    case (sz)
      2'd0:    est = CYC_W'(6) + (m << 2);
      2'd1:    est = CYC_W'(6) + CYC_W'(5) * (m >> 1) + ((m & CYC_W'(1)) << 2);
      default: est = CYC_W'(6) + CYC_W'(7) * (m >> 2) + ((m & CYC_W'(3)) << 2);
    endcase
  endfunction

  logic [2:0]        step3;
  logic [ADDR_W-1:0] step;
  logic [31:0]       opb;
  logic signed [63:0] prod;
  logic [95:0]       acc_next;
  logic [31:0]       fin_hi;

  assign step3    = (size_q == 2'd0) ? 3'd1 : (size_q == 2'd1) ? 3'd2 : 3'd4;
  assign step     = {{(ADDR_W-3){1'b0}}, step3};
  assign opb      = widen(mem_rdata, size_q);
  assign prod     = $signed(opa) * $signed(opb);
  assign acc_next = acc + {{32{prod[63]}}, prod};
  assign fin_hi   = {{16{acc[79]}}, acc[79:64]};

  assign busy     = (state != S_IDLE);
  assign mem_req  = (state == S_RDA) || (state == S_RDB);
  assign mem_addr = (state == S_RDB) ? ptr_b : ptr_a;
  assign sum_lo   = acc[31:0];
  assign sum_mid  = acc[63:32];
  assign sum_hi   = acc[95:64];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr_a     <= '0;
      ptr_b     <= '0;
      cnt       <= '0;
      size_q    <= '0;
      opa       <= '0;
      acc       <= '0;
      done      <= 1'b0;
      flag_ovf  <= 1'b0;
      flag_sign <= 1'b0;
      cycle_est <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ptr_a     <= base_a;
          ptr_b     <= base_b;
          cnt       <= elem_count;
          size_q    <= elem_size;
          acc       <= {init_hi, init_mid, init_lo};
          cycle_est <= est(elem_count, elem_size);
          flag_ovf  <= 1'b0;
          flag_sign <= 1'b0;
          state     <= (elem_count == '0) ? S_FIN : S_RDA;
        end
        S_RDA: state <= S_RDB;
        S_RDB: begin
          opa   <= opb;
          state <= S_MAC;
        end
        S_MAC: begin
          acc   <= acc_next;
          ptr_a <= ptr_a + step;
          ptr_b <= ptr_b + step;
          cnt   <= cnt - 1'b1;
          state <= (cnt == CNT_W'(1)) ? S_FIN : S_RDA;
        end
        S_FIN: begin
          acc[95:64] <= fin_hi;
          flag_sign  <= fin_hi[31];
          flag_ovf   <= (fin_hi != 32'd0) && (fin_hi != 32'hFFFF_FFFF);
          done       <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MAC) |=> (ptr_a == $past(ptr_a) + $past(step)) && (ptr_b == $past(ptr_b) + $past(step)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cycle_est));
  assert_top_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum_hi[31:16] == {16{sum_hi[15]}}));
  assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_sign == sum_hi[31]));
  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_ovf == ((sum_hi != 32'd0) && (sum_hi != 32'hFFFF_FFFF))));

endmodule

// File: tb/sop_sequencer_tb.sv
`timescale 1ns/1ps
module sop_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_a = '0, base_b = '0;
  logic [15:0] elem_count = '0;
  logic [1:0]  elem_size = '0;
  logic [31:0] init_lo = '0, init_mid = '0, init_hi = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, flag_ovf, flag_sign;
  logic [31:0] sum_lo, sum_mid, sum_hi, cycle_est;

  int checks = 0, failures = 0;
  int req_cnt = 0, bad_req = 0;
  int mode = 0;
  logic [31:0] salt = 32'h5A5A_1234;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sop_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_a(base_a), .base_b(base_b), .elem_count(elem_count), .elem_size(elem_size),
    .init_lo(init_lo), .init_mid(init_mid), .init_hi(init_hi),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .sum_lo(sum_lo), .sum_mid(sum_mid), .sum_hi(sum_hi),
    .flag_ovf(flag_ovf), .flag_sign(flag_sign), .cycle_est(cycle_est));

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (mode)
      1:       mem_word = 32'h8000_0000;
      2:       mem_word = 32'hFFFF_FFFF;
      default: mem_word = (a * 32'h9E37_79B1) ^ (a >> 7) ^ salt;
    endcase
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem_word(mem_addr);
      req_cnt <= req_cnt + 1;
      if (!busy) bad_req <= bad_req + 1;
    end
  end

  function automatic logic signed [31:0] elem(input logic [31:0] w, input logic [1:0] sz);
    if (sz == 2'd0)      elem = $signed({{24{w[7]}}, w[7:0]});
    else if (sz == 2'd1) elem = $signed({{16{w[15]}}, w[15:0]});
    else                 elem = $signed(w);
  endfunction

  function automatic logic [31:0] exp_cycles(input int n, input logic [1:0] sz);
    if (sz == 2'd0)      exp_cycles = 6 + 4 * n;
    else if (sz == 2'd1) exp_cycles = 6 + 5 * (n / 2) + 4 * (n % 2);
    else                 exp_cycles = 6 + 7 * (n / 4) + 4 * (n % 4);
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] pa, input logic [31:0] pb, input int n,
                     input logic [1:0] sz, input logic [31:0] lo, input logic [31:0] mid,
                     input logic [31:0] hi, input bit poke);
    logic [95:0] e;
    logic signed [63:0] p;
    logic [31:0] step, fh;
    int lat, req0;
    step = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    e = {hi, mid, lo};
    for (int i = 0; i < n; i++) begin
      p = elem(mem_word(pa + step * i), sz) * elem(mem_word(pb + step * i), sz);
      e = e + {{32{p[63]}}, p};
    end
    fh = {{16{e[79]}}, e[79:64]};
    req0 = req_cnt;
    @(negedge clk);
    base_a = pa; base_b = pb; elem_count = n[15:0]; elem_size = sz;
    init_lo = lo; init_mid = mid; init_hi = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check("R1 busy after start", {95'd0, busy}, 96'd1);
    while (!done && lat < 2000) begin
      if (poke && lat == 3) begin
        base_a = ~pa; elem_count = 16'd7; elem_size = ~sz; init_hi = ~hi; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (!done) begin
      checks++; failures++;
      $display("FAIL R2 run hung actual=no_done expected=done");
      return;
    end
    check((n == 0) ? "R10 latency" : "R2 latency", lat, 3 * n + 2);
    check("R1 busy low at done", {95'd0, busy}, 96'd0);
    check("R2 request count", req_cnt - req0, 2 * n);
    check("R3 R4 R5 low/mid words", {32'd0, sum_mid, sum_lo}, {32'd0, e[63:0]});
    check("R6 top word", sum_hi, fh);
    check("R7 sign flag", flag_sign, fh[31]);
    check("R8 overflow flag", flag_ovf, (fh != 0) && (fh != 32'hFFFF_FFFF));
    check("R9 cycle figure", cycle_est, exp_cycles(n, sz));
    @(negedge clk);
    check("R11 done pulse", {95'd0, done}, 96'd0);
    check("R11 result hold", {sum_hi, sum_mid, sum_lo}, {fh, e[63:0]});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #12;
    check("R1 reset busy", {95'd0, busy}, 96'd0);
    check("R11 reset done", {95'd0, done}, 96'd0);
    check("R2 reset req", {95'd0, mem_req}, 96'd0);
    rst_n = 1'b1;
    mode = 0;
    run(32'h100, 32'h200, 0, 2'd2, 32'h1111, 32'h2222, 32'h0000_8000, 0);
    run(32'h100, 32'h200, 0, 2'd0, 32'hAAAA, 32'hBBBB, 32'hABCD_1234, 0);
    run(32'h100, 32'h200, 0, 2'd1, 32'h1, 32'h2, 32'h0, 0);
    mode = 1;
    run(32'h40, 32'h80, 5, 2'd2, 32'h0, 32'h0, 32'h0, 0);
    run(32'h40, 32'h80, 6, 2'd3, 32'h0, 32'h0, 32'hFFFF_FFFF, 0);
    mode = 2;
    run(32'h10, 32'h30, 7, 2'd0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_7FFF, 0);
    run(32'h10, 32'h30, 3, 2'd1, 32'h0, 32'h0, 32'hFFFF_FFFF, 0);
    mode = 0;
    run(32'h1000, 32'h2003, 9, 2'd1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    for (int k = 0; k < 40; k++) begin
      salt = $urandom;
      run($urandom, $urandom, $urandom_range(0, 24), 2'($urandom_range(0, 3)),
          $urandom, $urandom, ($urandom_range(0, 1) == 1) ? $urandom : 32'd0,
          $urandom_range(0, 3) == 0);
    end
    check("R2 no request while idle", bad_req, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule